// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Controller

This block follows the power state of a DDR3-style memory device. It reads the clock-enable sample on each clock edge, together with a decoded self-refresh entry command, a flag that reports every bank as idle, and a flag that reports a read or write in progress. From these it chooses between the active state and three low-power states: precharge power-down, active power-down and self-refresh. It also sets the matching input-buffer and output-driver enables and raises a flag that runs the internal refresh engine while the device is in self-refresh.

Every state change is decided on the clock edge except one. Leaving self-refresh starts as soon as clock-enable rises, with no edge needed: the refresh flag drops and the clock/ODT input buffers turn back on at once. The state register then follows on the next edge. After any exit, commands stay blocked for a programmable number of clocks. Two rule breaks are flagged. One is dropping clock-enable during an access. The other is asking for self-refresh while a row is still open.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: In the cycles after a synchronous reset, `pwr_state` is 0 (active), the three buffer/driver enables are 1, `int_refresh` is 0 and both error outputs are 0. State codes: 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh.
- R2: In the active state with the exit window open, an edge with `cke` low, `access_busy` low and `all_banks_idle` high moves the state to 1. This applies unless `sre_cmd` is high with `cs_n` low.
- R3: In the active state with the exit window open, an edge with `cke` low, `access_busy` low and `all_banks_idle` low moves the state to 2.
- R4: In the active state with the exit window open, an edge with `cke` low, `sre_cmd` high, `cs_n` low, `all_banks_idle` high and `access_busy` low moves the state to 3.
- R5: A self-refresh request that would otherwise satisfy R4, but comes with `all_banks_idle` low, is rejected. The state becomes 2 and `err_sre_reject` is high for exactly the following cycle.
- R6: In the active state, an edge with `cke` low and `access_busy` high leaves the state at 0 and makes `err_cke_drop` high for exactly the following cycle. This holds whatever the other inputs are and whether or not the window is open.
- R7: In states 1 and 2, an edge with `cke` high returns the state to 0. An edge with `cke` low keeps the state, and no other input has any effect there.
- R8: In state 3, `int_refresh` equals NOT `cke` and `clk_odt_ibuf_en` equals `cke`, combinationally and without waiting for a clock edge. The first edge with `cke` high returns the state to 0.
- R9: In states 1 and 2, `cmd_ibuf_en` is 0, `clk_odt_ibuf_en` is 1 and `out_drv_en` is 0. In state 3, `cmd_ibuf_en` and `out_drv_en` are 0.
- R10: After the edge that returns the state to 0 from a low-power state, `cmd_accept` stays 0 for EXIT_CLKS cycles. During that window, `cke` low without an access in progress causes no state change.
- R11: `cmd_accept` is 1 only in state 0, with the window open, `cmd_valid` high and `cs_n` low. A high `cs_n` masks every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable sample |
| cs_n | input | 1 | Chip select, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| sre_cmd | input | 1 | Decoded self-refresh entry command |
| all_banks_idle | input | 1 | No row is open in any bank |
| access_busy | input | 1 | A read or write burst is in progress |
| pwr_state | output | 2 | Power state code (see R1) |
| cmd_ibuf_en | output | 1 | Enable for command, address and data input buffers |
| clk_odt_ibuf_en | output | 1 | Enable for clock and ODT input buffers |
| out_drv_en | output | 1 | Enable for output drivers |
| int_refresh | output | 1 | Run the internal refresh engine |
| cmd_accept | output | 1 | Presented command is accepted |
| err_cke_drop | output | 1 | Pulse: clock-enable dropped during an access |
| err_sre_reject | output | 1 | Pulse: self-refresh requested with a row open |

## Verification
A self-refresh request and an access in progress can meet on the same edge where clock-enable falls. Both then compete to decide the next state. The sweep drives every combination of the five control inputs from each of the four starting states, so these collisions come up directly. It judges them by expecting the access-drop error to win: the state stays active and no reject is flagged. The bench also lowers clock-enable inside the exit window. It checks that this is ignored, that commands stay blocked for exactly the programmed count, and that the window opens on the expected cycle.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'd0,
        PS_PRE_PD   = 2'd1,
        PS_ACT_PD   = 2'd2,
        PS_SELF_REF = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic cke;
        logic sre;
        logic cs_n;
        logic all_idle;
        logic busy;
    } pwr_in_t;

    typedef struct packed {
        pwr_state_e nxt;
        logic       err_drop;
        logic       err_sre;
    } decide_t;

    typedef struct packed {
        logic cmd_ibuf;
        logic clk_odt_ibuf;
        logic out_drv;
        logic int_refresh;
    } buf_en_t;

    function automatic decide_t decide(pwr_state_e cur, pwr_in_t in, logic window_open);
        decide_t r;
        r.nxt      = cur;
        r.err_drop = 1'b0;
        r.err_sre  = 1'b0;
        case (cur)
            PS_ACTIVE: begin
                if (!in.cke && in.busy) begin
                    r.err_drop = 1'b1;
                end else if (!in.cke && window_open) begin
                    if (in.sre && !in.cs_n) begin
                        if (in.all_idle) begin
                            r.nxt = PS_SELF_REF;
                        end else begin
                            r.nxt     = PS_ACT_PD;
                            r.err_sre = 1'b1;
                        end
                    end else begin
                        r.nxt = in.all_idle ? PS_PRE_PD : PS_ACT_PD;
                    end
                end
            end
            PS_PRE_PD, PS_ACT_PD, PS_SELF_REF: begin
                if (in.cke) r.nxt = PS_ACTIVE;
            end
            default: r.nxt = PS_ACTIVE;
        endcase
        return r;
    endfunction

    function automatic buf_en_t enables(pwr_state_e cur, logic cke);
        buf_en_t e;
        case (cur)
            PS_ACTIVE:   e = '{cmd_ibuf: 1'b1, clk_odt_ibuf: 1'b1, out_drv: 1'b1, int_refresh: 1'b0};
            PS_PRE_PD,
            PS_ACT_PD:   e = '{cmd_ibuf: 1'b0, clk_odt_ibuf: 1'b1, out_drv: 1'b0, int_refresh: 1'b0};
            PS_SELF_REF: e = '{cmd_ibuf: 1'b0, clk_odt_ibuf: cke, out_drv: 1'b0, int_refresh: !cke};
            default:     e = '{cmd_ibuf: 1'b1, clk_odt_ibuf: 1'b1, out_drv: 1'b1, int_refresh: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/cke_entry_fsm.sv
module cke_entry_fsm
    import cke_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_in_t    in,
    input  logic       window_open,
    output pwr_state_e st_q,
    output logic       exit_evt,
    output logic       err_drop_q,
    output logic       err_sre_q
);

    decide_t d;

    always_comb begin
        d = decide(st_q, in, window_open);
    end

    assign exit_evt = (st_q != PS_ACTIVE) && (d.nxt == PS_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PS_ACTIVE;
            err_drop_q <= 1'b0;
            err_sre_q  <= 1'b0;
        end else begin
            st_q       <= d.nxt;
            err_drop_q <= d.err_drop;
            err_sre_q  <= d.err_sre;
        end
    end

    p_sr_needs_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_ACTIVE && !in.cke && in.sre && !in.cs_n && !in.all_idle) |=> (st_q != PS_SELF_REF));

    p_reject_to_apd_r5: assert property (@(posedge clk) disable iff (rst)
        err_sre_q |-> (st_q == PS_ACT_PD));

    p_busy_holds_active_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_ACTIVE && !in.cke && in.busy) |=> (st_q == PS_ACTIVE && err_drop_q));

    p_pd_stays_low_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_q == PS_PRE_PD || st_q == PS_ACT_PD) && !in.cke) |=> (st_q == $past(st_q)));

    p_sr_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_SELF_REF && in.cke) |=> (st_q == PS_ACTIVE));

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
    parameter int EXIT_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic exit_evt,
    output logic window_open
);

    generate
        if (EXIT_CLKS == 0) begin : g_no_wait
            assign window_open = 1'b1;
        end else begin : g_wait
            localparam int CW = $clog2(EXIT_CLKS + 1);
            localparam logic [CW-1:0] LOAD = CW'(EXIT_CLKS);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (exit_evt) begin
                    cnt_q <= LOAD;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign window_open = (cnt_q == '0);

            p_load_closes_r10: assert property (@(posedge clk) disable iff (rst)
                exit_evt |=> !window_open);

            p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LOAD);
        end
    endgenerate

endmodule

// File: rtl/cke_buf_ctrl.sv
module cke_buf_ctrl
    import cke_pwr_pkg::*;
(
    input  pwr_state_e st,
    input  logic       cke,
    output buf_en_t    en
);

    always_comb begin
        en = enables(st, cke);
    end

endmodule

// File: rtl/cke_cmd_gate.sv
module cke_cmd_gate
    import cke_pwr_pkg::*;
(
    input  pwr_state_e st,
    input  logic       window_open,
    input  logic       cmd_valid,
    input  logic       cs_n,
    output logic       accept
);

    assign accept = (st == PS_ACTIVE) && window_open && cmd_valid && !cs_n;

endmodule

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
    import cke_pwr_pkg::*;
#(
    parameter int EXIT_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       cmd_valid,
    input  logic       sre_cmd,
    input  logic       all_banks_idle,
    input  logic       access_busy,
    output logic [1:0] pwr_state,
    output logic       cmd_ibuf_en,
    output logic       clk_odt_ibuf_en,
    output logic       out_drv_en,
    output logic       int_refresh,
    output logic       cmd_accept,
    output logic       err_cke_drop,
    output logic       err_sre_reject
);

    pwr_in_t    in_s;
    pwr_state_e st;
    logic       exit_evt;
    logic       window_open;
    buf_en_t    en;

    assign in_s = '{cke: cke, sre: sre_cmd, cs_n: cs_n, all_idle: all_banks_idle, busy: access_busy};

    cke_entry_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in         (in_s),
        .window_open(window_open),
        .st_q       (st),
        .exit_evt   (exit_evt),
        .err_drop_q (err_cke_drop),
        .err_sre_q  (err_sre_reject)
    );

    cke_exit_timer #(.EXIT_CLKS(EXIT_CLKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .exit_evt   (exit_evt),
        .window_open(window_open)
    );

    cke_buf_ctrl u_buf (
        .st (st),
        .cke(cke),
        .en (en)
    );

    cke_cmd_gate u_gate (
        .st         (st),
        .window_open(window_open),
        .cmd_valid  (cmd_valid),
        .cs_n       (cs_n),
        .accept     (cmd_accept)
    );

    assign pwr_state       = st;
    assign cmd_ibuf_en     = en.cmd_ibuf;
    assign clk_odt_ibuf_en = en.clk_odt_ibuf;
    assign out_drv_en      = en.out_drv;
    assign int_refresh     = en.int_refresh;

    p_pd_clk_on_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd1 || pwr_state == 2'd2) |-> (clk_odt_ibuf_en && !cmd_ibuf_en && !out_drv_en));

    p_refresh_only_sr_r8: assert property (@(posedge clk) disable iff (rst)
        int_refresh |-> (pwr_state == 2'd3 && !clk_odt_ibuf_en));

    p_cs_masks_r11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !cmd_accept);

    p_accept_active_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> (pwr_state == 2'd0 && cmd_ibuf_en));

endmodule

// File: tb/cke_pwr_ctrl_tb.sv
module cke_pwr_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EXIT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b1, cmd_valid = 1'b0, sre_cmd = 1'b0;
    logic all_banks_idle = 1'b1, access_busy = 1'b0;
    logic [1:0] pwr_state;
    logic cmd_ibuf_en, clk_odt_ibuf_en, out_drv_en, int_refresh;
    logic cmd_accept, err_cke_drop, err_sre_reject;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cke_pwr_ctrl #(.EXIT_CLKS(EXIT)) u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .sre_cmd(sre_cmd), .all_banks_idle(all_banks_idle), .access_busy(access_busy),
        .pwr_state(pwr_state), .cmd_ibuf_en(cmd_ibuf_en), .clk_odt_ibuf_en(clk_odt_ibuf_en),
        .out_drv_en(out_drv_en), .int_refresh(int_refresh), .cmd_accept(cmd_accept),
        .err_cke_drop(err_cke_drop), .err_sre_reject(err_sre_reject)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_in(input logic k, input logic s, input logic c, input logic i, input logic b);
        cke = k; sre_cmd = s; cs_n = c; all_banks_idle = i; access_busy = b;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0;
        set_in(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reach(input int s);
        do_reset();
        if (s != 0) begin
            case (s)
                1: set_in(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
                2: set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
                default: set_in(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            endcase
            @(posedge clk); #1;
            check(s == 1 ? "R2 entry" : (s == 2 ? "R3 entry" : "R4 entry"), pwr_state, s);
        end
    endtask

    task automatic check_en(input int st, input logic k);
        int ec, ek, eo, er;
        case (st)
            0: begin ec = 1; ek = 1; eo = 1; er = 0; end
            1, 2: begin ec = 0; ek = 1; eo = 0; er = 0; end
            default: begin ec = 0; ek = int'(k); eo = 0; er = int'(!k); end
        endcase
        check("R9 cmd_ibuf_en", cmd_ibuf_en, ec);
        check("R9 clk_odt_ibuf_en", clk_odt_ibuf_en, ek);
        check("R9 out_drv_en", out_drv_en, eo);
        check("R8 int_refresh", int_refresh, er);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check("R1 state", pwr_state, 0);
        check("R1 cmd_ibuf_en", cmd_ibuf_en, 1);
        check("R1 clk_odt_ibuf_en", clk_odt_ibuf_en, 1);
        check("R1 out_drv_en", out_drv_en, 1);
        check("R1 int_refresh", int_refresh, 0);
        check("R1 err_cke_drop", err_cke_drop, 0);
        check("R1 err_sre_reject", err_sre_reject, 0);

        // Sweep every input combination from every state (R2..R9)
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 32; v++) begin
                logic k, sr, c, id, b;
                int exp_st, exp_d, exp_r;
                k = v[0]; sr = v[1]; c = v[2]; id = v[3]; b = v[4];
                reach(s);
                @(negedge clk);
                set_in(k, sr, c, id, b);
                #1;
                if (s == 3) begin
                    check("R8 async refresh", int_refresh, int'(!k));
                    check("R8 async clk_odt", clk_odt_ibuf_en, int'(k));
                end
                exp_st = s; exp_d = 0; exp_r = 0;
                if (s == 0) begin
                    if (!k && b) exp_d = 1;
                    else if (!k && sr && !c) begin
                        if (id) exp_st = 3;
                        else begin exp_st = 2; exp_r = 1; end
                    end else if (!k) exp_st = id ? 1 : 2;
                end else if (k) begin
                    exp_st = 0;
                end
                @(posedge clk); #1;
                check(s == 0 ? "R2/R3/R4 next state" : (s == 3 ? "R8 next state" : "R7 next state"),
                      pwr_state, exp_st);
                check("R6 err_cke_drop", err_cke_drop, exp_d);
                check("R5 err_sre_reject", err_sre_reject, exp_r);
                check_en(exp_st, k);
            end
        end

        // Exit window and command gating (R10, R11)
        reach(1);
        @(negedge clk);
        set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        cmd_valid = 1'b1;
        @(posedge clk); #1;
        check("R7 exit to active", pwr_state, 0);
        check("R10 blocked after exit", cmd_accept, 0);
        for (int i = 1; i < EXIT; i++) begin
            @(negedge clk);
            cke = (i == 1) ? 1'b0 : 1'b1;
            @(posedge clk); #1;
            check("R10 low cke ignored in window", pwr_state, 0);
            check("R10 blocked in window", cmd_accept, 0);
        end
        @(negedge clk);
        cke = 1'b1;
        @(posedge clk); #1;
        check("R11 accept after window", cmd_accept, 1);
        @(negedge clk);
        cs_n = 1'b1; #1;
        check("R11 cs_n masks", cmd_accept, 0);
        cs_n = 1'b0; cmd_valid = 1'b0; #1;
        check("R11 no valid", cmd_accept, 0);

        // Error pulse lasts one cycle (R6)
        @(negedge clk);
        set_in(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        @(posedge clk); #1;
        check("R6 drop flagged", err_cke_drop, 1);
        check("R6 stays active", pwr_state, 0);
        check("R6 no reject on collision", err_sre_reject, 0);
        @(negedge clk);
        set_in(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R6 pulse clears", err_cke_drop, 0);

        // Self-refresh exit through full window (R8, R10)
        reach(3);
        @(negedge clk);
        cke = 1'b1; cmd_valid = 1'b1; cs_n = 1'b0; sre_cmd = 1'b0; #1;
        check("R8 refresh drops on cke", int_refresh, 0);
        check("R8 still in self-refresh", pwr_state, 3);
        @(posedge clk); #1;
        check("R8 exit state", pwr_state, 0);
        for (int i = 1; i < EXIT; i++) begin
            @(posedge clk); #1;
            check("R10 blocked after self-refresh exit", cmd_accept, 0);
        end
        @(posedge clk); #1;
        check("R10 window open", cmd_accept, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule